// File: doc/BRIEF.md
# Queue Doorbell Address Decoder

This block sits behind the notification window of a paravirtual PCI function. Software rings a virtqueue by writing that queue's 16-bit index to a doorbell location inside the window. The block compares every write against the doorbell location of each enabled queue. A location is computed as the window's base offset plus the queue's configured slot number scaled by a stride. When the write lands on a valid location, the block raises a one-cycle doorbell pulse that carries the written index. The queue engines downstream use that pulse to start work.

The stride is supplied as a raw byte count. A legal stride is zero or an even power of two, and the block turns it into a shift amount, so the decode needs no multiplier. A zero stride places every queue on the base offset. Queues whose slot numbers are equal share one location. In both cases the queue that gets rung is named by the written data, not by the slot that was hit. An illegal stride raises a configuration flag, and while it stands the block ignores all writes. A write that is too narrow, or that lands on no enabled slot, sets a sticky error flag and gives no pulse.

The block is a four-state machine that re-evaluates on every cycle, so writes may arrive back to back. Each state lasts one cycle and records the outcome of the previous cycle's write:
- IDLE: there was no write.
- RING: a doorbell was accepted.
- DROP: the write was silently discarded, because the stride is illegal or the index is out of range.
- FAULT: the write was in error.

From any state the next state is chosen in this order:
- IDLE when `wr_valid` is low.
- DROP when the stride is illegal.
- FAULT when the write is one byte wide or misses every slot.
- RING when the index is below the queue count.
- DROP otherwise.

Top module: `qnd_decoder`

## Requirements
- R1: After reset, `db_valid`, `wr_err` and `cfg_err` are all low.
- R2: Queue q's doorbell address is `cfg_base + (slot_q << log2(cfg_mult))`, truncated to the address width. Only queues with q below the queue count own a slot. A write of 2 bytes (`wr_size`=01) exactly at such an address, with `wr_data` below the queue count, makes `db_valid` high for one cycle in the cycle after the write, with `db_queue` equal to `wr_data`.
- R3: With `cfg_mult` = 0, every enabled queue's doorbell address is `cfg_base`. A write there rings the written index, and a write to any other address is a fault.
- R4: When several queues share a location, a hit on it rings the written index, whichever queue owns the slot. An index at or above the queue count gives no pulse and no error.
- R5: A stride of 1, or a stride that is not a power of two, drives `cfg_err` high from the cycle after it is applied. While the stride is illegal, writes give neither a pulse nor an error.
- R6: A one-byte write (`wr_size`=00) gives no pulse and sets `wr_err`.
- R7: A write whose address matches no enabled queue's slot gives no pulse and sets `wr_err`. This includes the slot of a queue at or above the queue count.
- R8: Once set, `wr_err` stays high until reset, even across later good writes.
- R9: Writes on consecutive cycles each produce their own result in consecutive cycles.
- R10: A 4-byte write (`wr_size`=10) or an 8-byte write (`wr_size`=11) at a valid slot rings like a 2-byte write. A queue count above NQ is treated as NQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mult | input | MULT_W | Doorbell stride in bytes |
| cfg_base | input | ADDR_W | Base offset of the doorbell area |
| cfg_nq | input | $clog2(NQ+1) | Number of enabled queues |
| cfg_offs | input | NQ*OFF_W | Per-queue slot numbers, queue 0 in the low bits |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write in the window |
| wr_size | input | 2 | Width code: 00=1, 01=2, 10=4, 11=8 bytes |
| wr_data | input | 16 | Written queue index |
| db_valid | output | 1 | Doorbell pulse |
| db_queue | output | 16 | Index rung |
| wr_err | output | 1 | Sticky write-error flag |
| cfg_err | output | 1 | Illegal stride flag |

## Verification
The hardest case to reach from the ports is a hit on a shared location: a write whose address belongs to one queue but whose data names another enabled queue. The other hard case is the same hit carrying an index beyond the queue count, which must stay silent and leave no error behind. Random slot numbers are drawn from a small range so that collisions between queues are frequent. Writes are aimed at the slot of a randomly chosen queue, while the written index is drawn independently and can run past the queue count. The random mix also covers illegal strides and the zero stride, and directed cases pin each of these down.

// File: rtl/qnd_pkg.sv
package qnd_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RING  = 2'd1,
        S_DROP  = 2'd2,
        S_FAULT = 2'd3
    } qnd_state_e;

    typedef enum logic [1:0] {
        SZ_B1 = 2'b00,
        SZ_B2 = 2'b01,
        SZ_B4 = 2'b10,
        SZ_B8 = 2'b11
    } qnd_size_e;

endpackage

// File: rtl/qnd_mult_check.sv
module qnd_mult_check #(
    parameter int MULT_W = 32,
    localparam int SH_W = $clog2(MULT_W)
) (
    input  logic [MULT_W-1:0] mult,
    output logic              ok,
    output logic              zero,
    output logic [SH_W-1:0]   shift
);

    always_comb begin
        zero  = (mult == '0);
        shift = '0;
        for (int i = 0; i < MULT_W; i++) begin
            if (mult[i]) begin
                shift = SH_W'(i);
            end
        end
        // legal: zero, or a single set bit that is not bit 0
        ok = zero || (((mult & (mult - 1'b1)) == '0) && !mult[0]);
    end

endmodule

// File: rtl/qnd_slot_match.sv
module qnd_slot_match #(
    parameter int NQ     = 8,
    parameter int OFF_W  = 8,
    parameter int ADDR_W = 16,
    parameter int SH_W   = 5,
    localparam int NQ_W  = $clog2(NQ + 1)
) (
    input  logic [ADDR_W-1:0]   base,
    input  logic [SH_W-1:0]     shift,
    input  logic                zero,
    input  logic [NQ*OFF_W-1:0] offs,
    input  logic [NQ_W-1:0]     eff_nq,
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit
);

    logic [NQ-1:0] hit_vec;

    for (genvar q = 0; q < NQ; q++) begin : g_slot
        logic [ADDR_W-1:0] slot;
        assign slot = zero ? base
                           : base + (ADDR_W'(offs[q*OFF_W +: OFF_W]) << shift);
        assign hit_vec[q] = (NQ_W'(q) < eff_nq) && (addr == slot);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/qnd_decoder.sv
module qnd_decoder #(
    parameter int NQ     = 8,
    parameter int OFF_W  = 8,
    parameter int ADDR_W = 16,
    parameter int MULT_W = 32,
    localparam int NQ_W  = $clog2(NQ + 1),
    localparam int SH_W  = $clog2(MULT_W),
    localparam int IDX_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MULT_W-1:0]   cfg_mult,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [NQ_W-1:0]     cfg_nq,
    input  logic [NQ*OFF_W-1:0] cfg_offs,
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [1:0]          wr_size,
    input  logic [IDX_W-1:0]    wr_data,
    output logic                db_valid,
    output logic [IDX_W-1:0]    db_queue,
    output logic                wr_err,
    output logic                cfg_err
);
    import qnd_pkg::*;

    qnd_state_e        state, next_state;
    logic              mult_ok, mult_zero, hit;
    logic [SH_W-1:0]   shift;
    logic [NQ_W-1:0]   eff_nq;

    assign eff_nq = (cfg_nq > NQ_W'(NQ)) ? NQ_W'(NQ) : cfg_nq;

    qnd_mult_check #(.MULT_W(MULT_W)) u_mult (
        .mult  (cfg_mult),
        .ok    (mult_ok),
        .zero  (mult_zero),
        .shift (shift)
    );

    qnd_slot_match #(
        .NQ(NQ), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .SH_W(SH_W)
    ) u_match (
        .base   (cfg_base),
        .shift  (shift),
        .zero   (mult_zero),
        .offs   (cfg_offs),
        .eff_nq (eff_nq),
        .addr   (wr_addr),
        .hit    (hit)
    );

    // classification of this cycle's write picks the next state
    always_comb begin
        if (!wr_valid)
            next_state = S_IDLE;
        else if (!mult_ok)
            next_state = S_DROP;
        else if (wr_size == SZ_B1 || !hit)
            next_state = S_FAULT;
        else if (wr_data < IDX_W'(eff_nq))
            next_state = S_RING;
        else
            next_state = S_DROP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next_state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_queue <= '0;
            wr_err   <= 1'b0;
            cfg_err  <= 1'b0;
        end else begin
            cfg_err <= !mult_ok;
            if (next_state == S_RING)  db_queue <= wr_data;
            if (next_state == S_FAULT) wr_err   <= 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            S_IDLE:  db_valid = 1'b0;
            S_RING:  db_valid = 1'b1;
            S_DROP:  db_valid = 1'b0;
            S_FAULT: db_valid = 1'b0;
            default: db_valid = 1'b0;
        endcase
    end

    assert_pulse_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> $past(wr_valid));

    assert_pulse_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> (db_queue < IDX_W'($past(eff_nq))));

    assert_bad_cfg_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !mult_ok) |=> !db_valid);

    assert_cfg_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mult == MULT_W'(1)) |=> cfg_err);

    assert_narrow_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && mult_ok && wr_size == SZ_B1) |=> (!db_valid && wr_err));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);

endmodule

// File: tb/qnd_decoder_tb.sv
module qnd_decoder_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NQ = 8;
    localparam int OFF_W = 8;
    localparam int ADDR_W = 16;
    localparam int MULT_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [MULT_W-1:0] cfg_mult = '0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [3:0] cfg_nq = '0;
    logic [NQ*OFF_W-1:0] cfg_offs = '0;
    logic wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [1:0] wr_size = '0;
    logic [15:0] wr_data = '0;
    logic db_valid, wr_err, cfg_err;
    logic [15:0] db_queue;

    int n_chk = 0;
    int n_fail = 0;
    bit exp_err = 1'b0;
    logic [OFF_W-1:0] m_off [NQ];

    always #5 clk = ~clk;

    qnd_decoder #(.NQ(NQ), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .MULT_W(MULT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mult(cfg_mult), .cfg_base(cfg_base),
        .cfg_nq(cfg_nq), .cfg_offs(cfg_offs), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
        .db_valid(db_valid), .db_queue(db_queue), .wr_err(wr_err), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit mult_legal(input logic [31:0] m);
        return (m == 0) || (((m & (m - 1)) == 0) && !m[0]);
    endfunction

    function automatic logic [15:0] slot_of(input int q);
        int sh = 0;
        for (int i = 0; i < 32; i++) if (cfg_mult == (32'd1 << i)) sh = i;
        if (cfg_mult == 0) return cfg_base;
        return cfg_base + (16'(m_off[q]) << sh);
    endfunction

    // 0 = nothing, 1 = doorbell, 2 = error
    function automatic int model(input logic [15:0] a, input logic [1:0] sz, input logic [15:0] d);
        bit h = 1'b0;
        int nq = (cfg_nq > NQ) ? NQ : int'(cfg_nq);
        if (!mult_legal(cfg_mult)) return 0;
        if (sz == 2'b00) return 2;
        for (int q = 0; q < nq; q++) if (slot_of(q) == a) h = 1'b1;
        if (!h) return 2;
        return (d < nq) ? 1 : 0;
    endfunction

    task automatic push_offs();
        for (int q = 0; q < NQ; q++) cfg_offs[q*OFF_W +: OFF_W] = m_off[q];
    endtask

    task automatic set_cfg(input logic [31:0] m, input logic [15:0] b, input int nq, input string req);
        wr_valid = 1'b0;
        cfg_mult = m; cfg_base = b; cfg_nq = 4'(nq);
        push_offs();
        @(negedge clk);
        chk(cfg_err == !mult_legal(m), req, cfg_err, !mult_legal(m));
    endtask

    task automatic do_write(input logic [15:0] a, input logic [1:0] sz, input logic [15:0] d, input string req);
        int e = model(a, sz, d);
        wr_valid = 1'b1; wr_addr = a; wr_size = sz; wr_data = d;
        @(negedge clk);
        if (e == 2) exp_err = 1'b1;
        chk(db_valid == (e == 1), req, db_valid, e == 1);
        if (e == 1) chk(db_queue == d, req, db_queue, d);
        chk(wr_err == exp_err, req, wr_err, exp_err);
    endtask

    task automatic idle();
        wr_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        exp_err = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int q = 0; q < NQ; q++) m_off[q] = OFF_W'(q);
        @(negedge clk);
        do_reset();
        chk(!db_valid && !wr_err && !cfg_err, "R1", {db_valid, wr_err, cfg_err}, 0);

        // R2 basic ring: base 0x100, stride 4, queue 3 at 0x10C
        set_cfg(32'd4, 16'h0100, 8, "R2");
        do_write(16'h010C, 2'b01, 16'd3, "R2");
        idle();
        // R10 wider write
        do_write(16'h0114, 2'b10, 16'd5, "R10");
        do_write(16'h0114, 2'b11, 16'd6, "R10");
        idle();
        // R4 shared slot: queues 2 and 6 both slot 2
        m_off[6] = 8'd2;
        set_cfg(32'd4, 16'h0100, 8, "R4");
        do_write(16'h0108, 2'b01, 16'd6, "R4");
        do_write(16'h0108, 2'b01, 16'd9, "R4");
        chk(!wr_err, "R4", wr_err, 0);
        // R9 back to back
        do_write(16'h0100, 2'b01, 16'd0, "R9");
        do_write(16'h0104, 2'b01, 16'd1, "R9");
        do_write(16'h0110, 2'b01, 16'd4, "R9");
        idle();
        // R10 queue count clamp
        set_cfg(32'd4, 16'h0100, 15, "R10");
        do_write(16'h011C, 2'b01, 16'd7, "R10");
        do_write(16'h011C, 2'b01, 16'd8, "R10");
        idle();
        // R3 zero stride
        set_cfg(32'd0, 16'h0200, 8, "R3");
        do_write(16'h0200, 2'b01, 16'd4, "R3");
        do_write(16'h0204, 2'b01, 16'd4, "R3");
        chk(wr_err, "R3", wr_err, 1);
        idle();
        do_reset();
        // R5 illegal strides
        set_cfg(32'd1, 16'h0100, 8, "R5");
        do_write(16'h0100, 2'b01, 16'd0, "R5");
        do_write(16'h0100, 2'b00, 16'd0, "R5");
        set_cfg(32'd6, 16'h0100, 8, "R5");
        do_write(16'h0103, 2'b01, 16'd1, "R5");
        set_cfg(32'd8, 16'h0100, 8, "R5");
        // R6 narrow write
        do_write(16'h0108, 2'b00, 16'd1, "R6");
        chk(wr_err, "R6", wr_err, 1);
        // R8 sticky across good write
        do_write(16'h0108, 2'b01, 16'd1, "R8");
        idle(); idle();
        chk(wr_err, "R8", wr_err, 1);
        do_reset();
        // R7 slot of disabled queue
        set_cfg(32'd8, 16'h0100, 4, "R7");
        do_write(16'h0128, 2'b01, 16'd1, "R7");
        chk(wr_err && !db_valid, "R7", {wr_err, db_valid}, 2);
        idle();

        // random mix
        for (int it = 0; it < 600; it++) begin
            if (it % 25 == 0) begin
                logic [31:0] ml [8] = '{32'd0, 32'd2, 32'd4, 32'd8, 32'd16, 32'd1, 32'd6, 32'd12};
                do_reset();
                for (int q = 0; q < NQ; q++) m_off[q] = OFF_W'($urandom_range(0, 7));
                set_cfg(ml[$urandom_range(0, 7)], 16'({$urandom_range(0, 255), 1'b0}),
                        $urandom_range(1, 8), "R5");
            end
            begin
                int pick = $urandom_range(0, 3);
                logic [15:0] a;
                int q = $urandom_range(0, NQ - 1);
                if (pick <= 1)      a = slot_of(q);
                else if (pick == 2) a = slot_of(q) + 16'd2;
                else                a = 16'($urandom);
                do_write(a, 2'($urandom_range(0, 3)), 16'($urandom_range(0, 9)), "R2");
                if ($urandom_range(0, 3) == 0) idle();
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule